// File: doc/BRIEF.md
# Interleaved Four-Bank Block Fill Controller

The controller loads one cache block of four 32-bit words from main memory. The memory is split into four one-word-wide banks that share a single 32-bit data bus. The cache presents a block address with a request/ready handshake. The controller then spends one bus cycle sending the address and starts a read in every bank at the same moment. After the banks' shared access time it moves the four words across the bus in four back-to-back cycles. Each returned word carries a valid flag and its index within the block, and a done pulse marks the last one.

In the default interleaved arrangement, word-address bits [1:0] choose the bank. The bank-local address is the block number, which is the same for all four banks, so one broadcast serves them all. A block fill then takes 1 + 15 + 4 = 20 bus cycles. A build parameter instead selects a single-bank arrangement for comparison. There one bank holds all four words, and each word needs its own full access and transfer, for 1 + 4×(15+1) = 65 cycles per block.

Top module: `block_fill_ctrl`

## Requirements
- R1: While reset is held and after it is released with no request, ready_o is 1, and word_valid_o, done_o and every bank_rd_o bit are 0.
- R2: A request is taken on a rising edge where req_i and ready_o are both 1. ready_o is 0 from the next cycle through the cycle of done_o, and it is 1 again in the cycle after done_o.
- R3: In interleaved mode, the cycle after the single address cycle (cycle 2, counting the cycle after acceptance as cycle 1) raises all four bank_rd_o bits together, with bank_addr_o equal to addr_i[31:4]. No strobe appears in any other cycle of the fill.
- R4: In interleaved mode, words come out in cycles 17, 18, 19 and 20 with word_idx_o equal to 0, 1, 2 and 3. Each word is the data of bank word_idx_o.
- R5: done_o is high for exactly one cycle, in the same cycle as the word with index 3.
- R6: An interleaved fill lasts exactly 20 cycles: the first word appears in cycle 17, and done_o is in cycle 20.
- R7: addr_i[3:0] has no effect. The block address is captured at acceptance, and later changes of addr_i do not affect the fill.
- R8: A request raised while a fill is in progress is ignored. The fill, its words and its timing are unchanged, and ready_o stays 0.
- R9: With SINGLE_BANK set, only bank_rd_o[0] is used. It pulses in cycles 2, 18, 34 and 50 with bank_addr_o = {addr_i[31:4], word index}. Word w appears in cycle 17+16w, and done_o is in cycle 65.
- R10: A new request raised in the cycle where ready_o returns is accepted at once, so fills can run back to back with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Block fill request |
| addr_i | input | 32 | Byte address of the block (low four bits ignored) |
| ready_o | output | 1 | Controller idle, request can be taken |
| bank_rd_o | output | 4 | Per-bank read start strobe |
| bank_addr_o | output | 30 | Bank-local word address, broadcast to all banks |
| bank_rdata_i | input | 128 | Read data, bank b on bits [32b+31:32b] |
| word_valid_o | output | 1 | A block word is on word_o this cycle |
| word_idx_o | output | 2 | Index of the word within the block |
| word_o | output | 32 | Returned word |
| done_o | output | 1 | Last word of the block this cycle |

## Verification
The bench sweeps block addresses with varied low nibbles, from zero up to all ones, through both the interleaved and the single-bank builds. Each bank returns data that encodes both its bank number and its local address, so a wrong bank, a wrong local address or a word taken at the wrong cycle shows up as a data mismatch. Fills run back to back, which separates a correct return of ready from a late or early one. Some fills receive a second request with a different address in mid-flight, which tells a truly ignored request apart from one that restarts the fill or changes its address.

// File: rtl/bfc_pkg.sv
package bfc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACC,
    ST_XFER
  } fill_st_e;

  // total cycles from acceptance to the done cycle
  function automatic int unsigned fill_cycles(int unsigned nb, int unsigned ac,
                                              int unsigned lat, bit single);
    return single ? ac + nb * (lat + 1) : ac + lat + nb;
  endfunction
endpackage

// File: rtl/bfc_seq.sv
module bfc_seq
  import bfc_pkg::*;
#(
  parameter int unsigned NUM_BANKS   = 4,
  parameter int unsigned ADDR_CYC    = 1,
  parameter int unsigned BANK_LAT    = 15,
  parameter bit          SINGLE_BANK = 1'b0,
  localparam int unsigned WIDX       = $clog2(NUM_BANKS),
  localparam int unsigned CNT_MAX    = (ADDR_CYC > BANK_LAT) ? ADDR_CYC : BANK_LAT,
  localparam int unsigned CNT_W      = $clog2(CNT_MAX + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  output logic            idle_o,
  output logic            acc_start_o,
  output logic            xfer_o,
  output logic            last_o,
  output logic [WIDX-1:0] word_o
);
  localparam logic [CNT_W-1:0] ADR_M1 = CNT_W'(ADDR_CYC - 1);
  localparam logic [CNT_W-1:0] LAT_M1 = CNT_W'(BANK_LAT - 1);
  localparam logic [WIDX-1:0]  LAST_W = WIDX'(NUM_BANKS - 1);

  fill_st_e         st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [WIDX-1:0]  word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      word_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q   <= ST_ADDR;
          cnt_q  <= ADR_M1;
          word_q <= '0;
        end
        ST_ADDR: if (cnt_q == '0) begin
          st_q  <= ST_ACC;
          cnt_q <= LAT_M1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
        ST_ACC: if (cnt_q == '0) st_q <= ST_XFER;
                else cnt_q <= cnt_q - 1'b1;
        ST_XFER: if (word_q == LAST_W) begin
          st_q <= ST_IDLE;
        end else begin
          word_q <= word_q + 1'b1;
          if (SINGLE_BANK) begin
            st_q  <= ST_ACC;
            cnt_q <= LAT_M1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign idle_o      = (st_q == ST_IDLE);
  assign acc_start_o = (st_q == ST_ACC) && (cnt_q == LAT_M1);
  assign xfer_o      = (st_q == ST_XFER);
  assign last_o      = (word_q == LAST_W);
  assign word_o      = word_q;

  // R9: in single-bank mode each non-final word is followed by a fresh access
  a_r9_reaccess: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_o && !last_o) |=> (SINGLE_BANK ? acc_start_o : xfer_o));

  // R4: the word index never moves while banks are being accessed
  a_r4_word_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ACC && cnt_q != '0) |=> $stable(word_o));
endmodule

// File: rtl/bfc_addr_gen.sv
module bfc_addr_gen #(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned NUM_BANKS   = 4,
  parameter bit          SINGLE_BANK = 1'b0,
  localparam int unsigned WIDX       = $clog2(NUM_BANKS),
  localparam int unsigned OFF_W      = 2 + WIDX,
  localparam int unsigned BLK_W      = ADDR_W - OFF_W,
  localparam int unsigned BADDR_W    = ADDR_W - 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [BLK_W-1:0]   blk_i,
  input  logic [WIDX-1:0]    word_i,
  output logic [BADDR_W-1:0] bank_addr_o
);
  logic [BLK_W-1:0] blk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     blk_q <= '0;
    else if (load_i) blk_q <= blk_i;
  end

  if (SINGLE_BANK) begin : g_single
    // one bank holds the whole block: local address is the full word address
    assign bank_addr_o = {blk_q, word_i};
  end else begin : g_ilv
    logic unused_word;
    assign unused_word = ^word_i;
    assign bank_addr_o = BADDR_W'(blk_q);
  end
endmodule

// File: rtl/bfc_bank_io.sv
module bfc_bank_io #(
  parameter int unsigned NUM_BANKS   = 4,
  parameter int unsigned WORD_W      = 32,
  parameter bit          SINGLE_BANK = 1'b0,
  localparam int unsigned WIDX       = $clog2(NUM_BANKS)
) (
  input  logic                        acc_start_i,
  input  logic                        xfer_i,
  input  logic [WIDX-1:0]             word_i,
  input  logic [NUM_BANKS*WORD_W-1:0] rdata_i,
  output logic [NUM_BANKS-1:0]        bank_rd_o,
  output logic [WORD_W-1:0]           word_o
);
  logic [WORD_W-1:0] bank_word [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bank_word[b] = rdata_i[b*WORD_W +: WORD_W];
    if (SINGLE_BANK && b != 0) begin : g_off
      assign bank_rd_o[b] = 1'b0;
    end else begin : g_on
      assign bank_rd_o[b] = acc_start_i;
    end
  end

  if (SINGLE_BANK) begin : g_sel_single
    logic unused_sel;
    assign unused_sel = ^word_i ^ (^rdata_i[NUM_BANKS*WORD_W-1:WORD_W]);
    assign word_o = xfer_i ? bank_word[0] : '0;
  end else begin : g_sel_ilv
    assign word_o = xfer_i ? bank_word[word_i] : '0;
  end
endmodule

// File: rtl/block_fill_ctrl.sv
module block_fill_ctrl
  import bfc_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned WORD_W      = 32,
  parameter int unsigned NUM_BANKS   = 4,
  parameter int unsigned ADDR_CYC    = 1,
  parameter int unsigned BANK_LAT    = 15,
  parameter bit          SINGLE_BANK = 1'b0,
  localparam int unsigned WIDX       = $clog2(NUM_BANKS),
  localparam int unsigned OFF_W      = 2 + WIDX,
  localparam int unsigned BADDR_W    = ADDR_W - 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        req_i,
  input  logic [ADDR_W-1:0]           addr_i,
  output logic                        ready_o,
  output logic [NUM_BANKS-1:0]        bank_rd_o,
  output logic [BADDR_W-1:0]          bank_addr_o,
  input  logic [NUM_BANKS*WORD_W-1:0] bank_rdata_i,
  output logic                        word_valid_o,
  output logic [WIDX-1:0]             word_idx_o,
  output logic [WORD_W-1:0]           word_o,
  output logic                        done_o
);
  localparam int unsigned FILL_CYC = fill_cycles(NUM_BANKS, ADDR_CYC, BANK_LAT, SINGLE_BANK);
  localparam int unsigned FIRST_CYC = ADDR_CYC + BANK_LAT + 1;
  localparam int unsigned LEN_W = $clog2(FILL_CYC + 2);

  logic            accept;
  logic            acc_start, xfer, last;
  logic [WIDX-1:0] word;
  logic            unused_lo;

  assign unused_lo = ^addr_i[OFF_W-1:0];
  assign accept    = req_i && ready_o;

  bfc_seq #(
    .NUM_BANKS  (NUM_BANKS),
    .ADDR_CYC   (ADDR_CYC),
    .BANK_LAT   (BANK_LAT),
    .SINGLE_BANK(SINGLE_BANK)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (accept),
    .idle_o     (ready_o),
    .acc_start_o(acc_start),
    .xfer_o     (xfer),
    .last_o     (last),
    .word_o     (word)
  );

  bfc_addr_gen #(
    .ADDR_W     (ADDR_W),
    .NUM_BANKS  (NUM_BANKS),
    .SINGLE_BANK(SINGLE_BANK)
  ) u_addr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept),
    .blk_i      (addr_i[ADDR_W-1:OFF_W]),
    .word_i     (word),
    .bank_addr_o(bank_addr_o)
  );

  bfc_bank_io #(
    .NUM_BANKS  (NUM_BANKS),
    .WORD_W     (WORD_W),
    .SINGLE_BANK(SINGLE_BANK)
  ) u_io (
    .acc_start_i(acc_start),
    .xfer_i     (xfer),
    .word_i     (word),
    .rdata_i    (bank_rdata_i),
    .bank_rd_o  (bank_rd_o),
    .word_o     (word_o)
  );

  assign word_valid_o = xfer;
  assign word_idx_o   = word;
  assign done_o       = xfer && last;

  // cycle count since acceptance, kept only for the timing assertions
  logic [LEN_W-1:0] len_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       len_q <= '0;
    else if (accept)   len_q <= LEN_W'(1);
    else if (!ready_o) len_q <= len_q + 1'b1;
  end

  a_r2_busy_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !ready_o);

  a_r2_ready_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> ready_o);

  a_r5_done_on_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (word_valid_o && word_idx_o == WIDX'(NUM_BANKS - 1)));

  a_r5_done_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r6_fill_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (len_q == LEN_W'(FILL_CYC)));

  a_r6_first_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_valid_o && word_idx_o == '0) |-> (len_q == LEN_W'(FIRST_CYC)));

  a_r4_idx_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!SINGLE_BANK && word_valid_o && !done_o) |=>
      (word_valid_o && word_idx_o == $past(word_idx_o) + 1'b1));

  a_r3_strobe_shape: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|bank_rd_o) |-> (SINGLE_BANK ? (bank_rd_o == NUM_BANKS'(1)) : (&bank_rd_o)));

  a_r3_no_strobe_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (bank_rd_o == '0 && !word_valid_o));
endmodule

// File: tb/block_fill_ctrl_bench.sv
module bfc_bank_model #(
  parameter int unsigned BANK_ID = 0,
  parameter int unsigned LAT     = 15,
  parameter int unsigned AW      = 30
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_i,
  input  logic [AW-1:0] addr_i,
  output logic [31:0]   data_o
);
  logic [AW-1:0] a_q;
  logic          busy_q;
  int unsigned   cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0; busy_q <= 1'b0; cnt_q <= 0;
    end else if (rd_i) begin
      a_q <= addr_i; busy_q <= 1'b1; cnt_q <= LAT - 1;
    end else if (cnt_q != 0) begin
      cnt_q <= cnt_q - 1;
    end
  end

  assign data_o = (busy_q && cnt_q == 0) ?
                  ({BANK_ID[1:0], a_q[29:0]} ^ 32'h1357_9BDF) : 32'hDEAD_BEEF;
endmodule

module block_fill_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  int n_run = 0;
  int n_fail = 0;

  logic         req  [2];
  logic [31:0]  addr [2];
  logic         rdy  [2];
  logic [3:0]   rd   [2];
  logic [29:0]  ba   [2];
  logic [127:0] rdat [2];
  logic         vld  [2];
  logic [1:0]   idx  [2];
  logic [31:0]  wrd  [2];
  logic         dn   [2];

  for (genvar m = 0; m < 2; m++) begin : g_mode
    block_fill_ctrl #(.SINGLE_BANK(m == 1)) u_block_fill_ctrl (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .req_i       (req[m]),
      .addr_i      (addr[m]),
      .ready_o     (rdy[m]),
      .bank_rd_o   (rd[m]),
      .bank_addr_o (ba[m]),
      .bank_rdata_i(rdat[m]),
      .word_valid_o(vld[m]),
      .word_idx_o  (idx[m]),
      .word_o      (wrd[m]),
      .done_o      (dn[m])
    );
    for (genvar b = 0; b < 4; b++) begin : g_bank
      bfc_bank_model #(.BANK_ID(b)) u_bank (
        .clk_i (clk),
        .rst_ni(rst_n),
        .rd_i  (rd[m][b]),
        .addr_i(ba[m]),
        .data_o(rdat[m][b*32 +: 32])
      );
    end
  end

  function automatic logic [31:0] exp_data(int bank, logic [29:0] baddr);
    return {2'(bank), baddr} ^ 32'h1357_9BDF;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  // called at a negedge with ready expected high; returns at the negedge where ready is back
  task automatic fill(int m, logic [31:0] a, bit poke);
    int n = (m == 1) ? 65 : 20;
    logic [27:0] blk = a[31:4];
    chk("R10 ready before request", 32'(rdy[m]), 32'd1);
    req[m]  = 1'b1;
    addr[m] = a;
    @(posedge clk);
    @(negedge clk);
    req[m]  = 1'b0;
    addr[m] = ~a;  // address must already be captured (R7)
    for (int c = 1; c <= n + 1; c++) begin
      bit          vexp;
      int          w;
      logic [3:0]  rdexp;
      logic [29:0] baexp;
      if (c > 1) @(negedge clk);
      vexp = (c >= 17) && (c <= n) && (m == 0 || (c - 17) % 16 == 0);
      w = (m == 1) ? (c - 17) / 16 : c - 17;
      rdexp = 4'h0;
      baexp = '0;
      if (m == 0 && c == 2) begin
        rdexp = 4'hF; baexp = 30'(blk);
      end
      if (m == 1 && c >= 2 && c <= n && (c - 2) % 16 == 0) begin
        rdexp = 4'h1; baexp = {blk, 2'((c - 2) / 16)};
      end
      chk(poke ? "R8 ready while busy" : "R2 ready", 32'(rdy[m]), 32'(c == n + 1));
      chk(m == 1 ? "R9 word valid timing" : "R6 word valid timing", 32'(vld[m]), 32'(vexp));
      chk("R5 done", 32'(dn[m]), 32'(c == n));
      chk(m == 1 ? "R9 bank strobes" : "R3 bank strobes", 32'(rd[m]), 32'(rdexp));
      if (rdexp != 0)
        chk(m == 1 ? "R9 bank address" : "R3 bank address", 32'(ba[m]), 32'(baexp));
      if (vexp) begin
        chk("R4 word index", 32'(idx[m]), 32'(w));
        chk(poke ? "R8 word data" : "R4/R7 word data", wrd[m],
            (m == 1) ? exp_data(0, {blk, 2'(w)}) : exp_data(w, 30'(blk)));
      end
      if (poke && c == 5) begin
        req[m] = 1'b1; addr[m] = a ^ 32'h0000_0150;
      end
      if (poke && c == 6) req[m] = 1'b0;
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int m = 0; m < 2; m++) begin
      req[m] = 1'b0; addr[m] = '0;
    end
    @(negedge clk);
    @(negedge clk);
    for (int m = 0; m < 2; m++) begin
      chk("R1 ready in reset", 32'(rdy[m]), 32'd1);
      chk("R1 valid in reset", 32'(vld[m]), 32'd0);
      chk("R1 done in reset", 32'(dn[m]), 32'd0);
      chk("R1 strobes in reset", 32'(rd[m]), 32'd0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    for (int m = 0; m < 2; m++) begin
      chk("R1 ready after reset", 32'(rdy[m]), 32'd1);
      chk("R1 valid after reset", 32'(vld[m]), 32'd0);
      chk("R1 strobes after reset", 32'(rd[m]), 32'd0);
    end
    // interleaved sweep, back to back (R10)
    for (int b = 0; b < 48; b++) begin
      logic [31:0] a = ((32'(b) * 32'h0009_E371) << 4) | 32'(b % 16);
      fill(0, a, (b % 8) == 3);
    end
    fill(0, 32'hFFFF_FFFF, 1'b0);
    fill(0, 32'h0000_000F, 1'b1);
    // single-bank sweep
    for (int b = 0; b < 12; b++) begin
      logic [31:0] a = ((32'(b) * 32'h0031_7A5D) << 4) | 32'((b * 5) % 16);
      fill(1, a, b == 5);
    end
    fill(1, 32'hFFFF_FFF3, 1'b0);
    finish_run();
  end
endmodule